// File: doc/BRIEF.md
# Dual Periodic Timer with Masked Interrupt

This block is a two-channel periodic timer, reached through a 32-bit register port. Each channel has a reload limit, a running count and a control word. The control word picks one of four count rates and starts or stops the channel. A running channel counts down from its limit. When it expires it reloads the limit, so it fires at a fixed period, and it sets its bit in a sticky raw interrupt register.

A mask register decides which raw bits may drive the single interrupt output. A write-one-to-clear acknowledge register clears raw bits. The interrupt output falls on an acknowledge only when no masked raw bit is left pending. A free-running time register gives software a timestamp that never repeats between reads.

All count rates come from one system clock. A prescaler for each rate emits a one-cycle enable. The prescaler ratios are parameters, so a bench can scale them down.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both channels are stopped, and every count, limit, control word, mask bit and raw bit reads zero. The interrupt output is low.
- R2: The register map, by byte address, is as follows. Channel 0 has its limit at 0x00, its count at 0x04 and its control at 0x08. Channel 1 has the same three at 0x10, 0x14 and 0x18. The limit and control words read back what was written. In the control word, bits [2:0] are the rate code and bit 4 is run (1 = start, 0 = stop); all other control bits read as zero.
- R3: Rate codes 4, 5, 6 and 7 advance the count once every DIV4, DIV5, DIV6 and DIV7 system cycles. Any other code leaves the count unchanged while running.
- R4: A control write with run=1 loads the limit into the count. Each rate tick then decrements the count. A tick that finds the count at 0 or 1 reloads the limit and marks an expiry, so with a limit L ≥ 1 expiries are L × DIVn cycles apart.
- R5: A stopped channel keeps its count unchanged.
- R6: Raw register 0x50 holds bit 0 for channel 0 and bit 1 for channel 1. An expiry sets the bit. A write to 0x4C clears each raw bit written as 1.
- R7: Mask register 0x48 holds two bits. Address 0x54 reads raw AND mask.
- R8: The interrupt output rises only on an expiry of a channel whose mask bit is set. A mask write alone does not raise it.
- R9: An acknowledge write lowers the interrupt output only when no raw bit under the mask is still set after the clear.
- R10: Time register 0x38 increments on every system clock, so successive reads return strictly increasing values.
- R11: Unmapped addresses and the acknowledge address read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 7 | Byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that each prescaler ratio is at least 2, so a rate enable never stays high for two cycles running. They also assume that only one register write happens per cycle, so a limit write and a start never coincide. The bench uses small ratios (7, 6, 5, 3) and issues writes one at a time with a gap between them. It measures expiry periods by polling the raw register on every cycle, and it only acknowledges once the last expiry is at least three cycles away.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_COUNT = 2;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 7;
  localparam int SEL_W    = 3;
  localparam int RATE_CNT = 4;

  localparam logic [ADDR_W-1:0] A_TIME   = 7'h38;
  localparam logic [ADDR_W-1:0] A_MASK   = 7'h48;
  localparam logic [ADDR_W-1:0] A_ACK    = 7'h4C;
  localparam logic [ADDR_W-1:0] A_RAW    = 7'h50;
  localparam logic [ADDR_W-1:0] A_MASKED = 7'h54;
  localparam int CH_STRIDE = 16;
  localparam int OFF_LIMIT = 0;
  localparam int OFF_COUNT = 4;
  localparam int OFF_CTRL  = 8;

  typedef struct packed {
    logic [CH_COUNT-1:0] limitWr;
    logic [CH_COUNT-1:0] startWr;
    logic                maskWr;
    logic                ackWr;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_rate_gen.sv
module tmr_rate_gen #(
  parameter int DIV4 = 7,
  parameter int DIV5 = 6,
  parameter int DIV6 = 5,
  parameter int DIV7 = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  output logic [tmr_pkg::RATE_CNT-1:0] rateTick
);
  for (genvar g = 0; g < tmr_pkg::RATE_CNT; g++) begin : g_rate
    localparam int D  = (g == 0) ? DIV4 : (g == 1) ? DIV5 : (g == 2) ? DIV6 : DIV7;
    localparam int CW = (D > 2) ? $clog2(D) : 1;
    logic [CW-1:0] preCnt;

    assign rateTick[g] = (preCnt == CW'(D - 1));

    always_ff @(posedge clk) begin
      if (!rstN)            preCnt <= '0;
      else if (rateTick[g]) preCnt <= '0;
      else                  preCnt <= preCnt + 1'b1;
    end

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      rateTick[g] |=> !rateTick[g]);
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [3:0]                       ctrlBits,
  output tmrStrobe_t                       strobe,
  output logic [CH_COUNT-1:0]              chRun,
  output logic [CH_COUNT-1:0][SEL_W-1:0]   chSel
);
  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * CH_STRIDE);

    assign strobe.limitWr[c] = wrEn && (addr == BASE + ADDR_W'(OFF_LIMIT));
    assign strobe.startWr[c] = wrEn && (addr == BASE + ADDR_W'(OFF_CTRL));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chRun[c] <= 1'b0;
        chSel[c] <= '0;
      end else if (strobe.startWr[c]) begin
        chRun[c] <= ctrlBits[3];
        chSel[c] <= ctrlBits[2:0];
      end
    end

    // R2
    run_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.startWr[c] |=> (chRun[c] == $past(ctrlBits[3])));
  end

  assign strobe.maskWr = wrEn && (addr == A_MASK);
  assign strobe.ackWr  = wrEn && (addr == A_ACK);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  tmrStrobe_t                       strobe,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [CH_COUNT-1:0]              chRun,
  input  logic [CH_COUNT-1:0][SEL_W-1:0]   chSel,
  input  logic [RATE_CNT-1:0]              rateTick,
  output logic [CH_COUNT-1:0][DATA_W-1:0]  count,
  output logic [CH_COUNT-1:0][DATA_W-1:0]  limit,
  output logic [CH_COUNT-1:0]              raw,
  output logic [CH_COUNT-1:0]              mask,
  output logic                             irqOut,
  output logic [DATA_W-1:0]                timeVal
);
  logic [CH_COUNT-1:0] chTick;
  logic [CH_COUNT-1:0] expire;
  logic [CH_COUNT-1:0] ackBits;
  logic [CH_COUNT-1:0] rawNext;
  logic                irqNext;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    assign chTick[c] = chRun[c] && chSel[c][SEL_W-1] && rateTick[chSel[c][1:0]];
    assign expire[c] = chTick[c] && (count[c] <= DATA_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        limit[c] <= '0;
        count[c] <= '0;
      end else begin
        if (strobe.limitWr[c]) limit[c] <= wrData;
        if (strobe.startWr[c] && wrData[4]) count[c] <= limit[c];
        else if (expire[c])                 count[c] <= limit[c];
        else if (chTick[c])                 count[c] <= count[c] - 1'b1;
      end
    end

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!chRun[c] && !strobe.startWr[c]) |=> $stable(count[c]));
    // R6
    expire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] |=> raw[c]);
  end

  assign ackBits = strobe.ackWr ? wrData[CH_COUNT-1:0] : '0;
  assign rawNext = (raw & ~ackBits) | expire;

  always_comb begin
    irqNext = irqOut | (|(expire & mask));
    if (strobe.ackWr && !(|(rawNext & mask))) irqNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      raw     <= '0;
      mask    <= '0;
      irqOut  <= 1'b0;
      timeVal <= '0;
    end else begin
      raw     <= rawNext;
      irqOut  <= irqNext;
      timeVal <= timeVal + 1'b1;
      if (strobe.maskWr) mask <= wrData[CH_COUNT-1:0];
    end
  end

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|(expire & mask)));
  // R9
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackWr && expire == '0 && ((raw & ~wrData[CH_COUNT-1:0] & mask) == '0)) |=> !irqOut);
  // R10
  time_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (timeVal == $past(timeVal) + 1'b1));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import tmr_pkg::*;
#(
  parameter int DIV4 = 7,
  parameter int DIV5 = 6,
  parameter int DIV6 = 5,
  parameter int DIV7 = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [6:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irqOut
);
  tmrStrobe_t                      strobe;
  logic [CH_COUNT-1:0]             chRun;
  logic [CH_COUNT-1:0][SEL_W-1:0]  chSel;
  logic [RATE_CNT-1:0]             rateTick;
  logic [CH_COUNT-1:0][DATA_W-1:0] count;
  logic [CH_COUNT-1:0][DATA_W-1:0] limit;
  logic [CH_COUNT-1:0]             raw;
  logic [CH_COUNT-1:0]             mask;
  logic [DATA_W-1:0]               timeVal;

  tmr_rate_gen #(.DIV4(DIV4), .DIV5(DIV5), .DIV6(DIV6), .DIV7(DIV7)) i_rate (
    .clk(clk), .rstN(rstN), .rateTick(rateTick));

  tmr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .ctrlBits({wrData[4], wrData[2:0]}),
    .strobe(strobe), .chRun(chRun), .chSel(chSel));

  tmr_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .chRun(chRun), .chSel(chSel), .rateTick(rateTick),
    .count(count), .limit(limit), .raw(raw), .mask(mask),
    .irqOut(irqOut), .timeVal(timeVal));

  always_comb begin
    rdData = '0;
    for (int c = 0; c < CH_COUNT; c++) begin
      if (addr == ADDR_W'(c * CH_STRIDE + OFF_LIMIT)) rdData = limit[c];
      if (addr == ADDR_W'(c * CH_STRIDE + OFF_COUNT)) rdData = count[c];
      if (addr == ADDR_W'(c * CH_STRIDE + OFF_CTRL))  rdData = {27'd0, chRun[c], 1'b0, chSel[c]};
    end
    case (addr)
      A_TIME:   rdData = timeVal;
      A_MASK:   rdData = {{(DATA_W-CH_COUNT){1'b0}}, mask};
      A_RAW:    rdData = {{(DATA_W-CH_COUNT){1'b0}}, raw};
      A_MASKED: rdData = {{(DATA_W-CH_COUNT){1'b0}}, raw & mask};
      default:  ;
    endcase
  end
endmodule

// File: tb/test_dual_tick_timer.sv
`timescale 1ns/1ps
module test_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  dual_tick_timer #(.DIV4(7), .DIV5(6), .DIV6(5), .DIV7(3)) i_dual_tick_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int divOf(input int sel);
    case (sel)
      4: return 7;
      5: return 6;
      6: return 5;
      default: return 3;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b0;
    addr = a;
    #1 d = rdData;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitRaw(input logic [1:0] bits, output int when);
    logic [31:0] v;
    when = -1;
    for (int i = 0; i < 3000; i++) begin
      rd(7'h50, v);
      if ((v[1:0] & bits) == bits) begin
        when = cyc;
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b, c;
    int t0, t1, t2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    foreach (v[i]) if (i < 1) ;
    rd(7'h00, v); check("R1 limit0", v, 0);
    rd(7'h04, v); check("R1 count0", v, 0);
    rd(7'h08, v); check("R1 ctrl0", v, 0);
    rd(7'h14, v); check("R1 count1", v, 0);
    rd(7'h18, v); check("R1 ctrl1", v, 0);
    rd(7'h48, v); check("R1 mask", v, 0);
    rd(7'h50, v); check("R1 raw", v, 0);
    check("R1 irq", {31'd0, irqOut}, 0);

    // R2 readback
    wr(7'h10, 32'h1234);
    rd(7'h10, v); check("R2 limit1", v, 32'h1234);
    wr(7'h18, 32'hFFFF_FF13);
    rd(7'h18, v); check("R2 ctrl1 readback", v, 32'h13);
    wr(7'h18, 32'h0);
    rd(7'h18, v); check("R2 ctrl1 stop", v, 32'h0);

    // R11 unmapped and ack address
    rd(7'h20, v); check("R11 unmapped", v, 0);
    rd(7'h4C, v); check("R11 ack read", v, 0);

    // R3 R4 R6 period sweep on channel 0
    for (int sel = 4; sel < 8; sel++) begin
      for (int lim = 1; lim < 4; lim++) begin
        wr(7'h00, lim);
        wr(7'h08, 32'h10 | sel);
        waitRaw(2'b01, t0);
        wr(7'h4C, 32'h1);
        waitRaw(2'b01, t1);
        wr(7'h4C, 32'h1);
        waitRaw(2'b01, t2);
        check($sformatf("R4 period sel%0d lim%0d", sel, lim), t2 - t1, lim * divOf(sel));
        wr(7'h08, 32'h0);
        wr(7'h4C, 32'h1);
      end
    end
    rd(7'h50, v); check("R6 ack clears raw", v, 0);

    // R3 non-counting code, R4 start load
    wr(7'h00, 3);
    wr(7'h08, 32'h12);
    rd(7'h04, v); check("R4 start loads limit", v, 3);
    repeat (60) @(negedge clk);
    rd(7'h04, v); check("R3 code 2 no count", v, 3);
    rd(7'h50, v); check("R3 code 2 no expiry", v, 0);
    wr(7'h08, 32'h0);

    // R5 stopped channel holds
    wr(7'h00, 20);
    wr(7'h08, 32'h15);
    repeat (40) @(negedge clk);
    wr(7'h08, 32'h05);
    rd(7'h04, a);
    repeat (30) @(negedge clk);
    rd(7'h04, b);
    check("R5 hold", b, a);
    check("R5 moved below limit", {31'd0, (a < 20 && a > 0)}, 1);
    wr(7'h4C, 32'h3);

    // R7 R8 masking
    wr(7'h00, 2);
    wr(7'h08, 32'h17);
    waitRaw(2'b01, t0);
    check("R8 unmasked expiry no irq", {31'd0, irqOut}, 0);
    rd(7'h54, v); check("R7 masked read zero", v, 0);
    wr(7'h08, 32'h07);
    wr(7'h48, 32'h3);
    rd(7'h54, v); check("R7 masked read", v, 1);
    check("R8 mask write no irq", {31'd0, irqOut}, 0);
    wr(7'h4C, 32'h1);
    wr(7'h08, 32'h17);
    waitRaw(2'b01, t0);
    check("R8 masked expiry irq", {31'd0, irqOut}, 1);

    // R9 acknowledge ordering
    wr(7'h10, 2);
    wr(7'h18, 32'h16);
    waitRaw(2'b10, t0);
    wr(7'h08, 32'h0);
    wr(7'h18, 32'h0);
    wr(7'h4C, 32'h1);
    rd(7'h50, v); check("R9 raw after ack0", v, 2);
    check("R9 irq held by ch1", {31'd0, irqOut}, 1);
    wr(7'h4C, 32'h2);
    rd(7'h50, v); check("R9 raw after ack1", v, 0);
    check("R9 irq dropped", {31'd0, irqOut}, 0);

    // R10 time register
    rd(7'h38, a);
    rd(7'h38, b);
    repeat (5) @(negedge clk);
    rd(7'h38, c);
    check("R10 step", b - a, 1);
    check("R10 increasing", {31'd0, (c > b)}, 1);
    check("R10 elapsed", c - b, 6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule